// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Slice

This block is one output slice of a small programmable logic array. A configurable AND plane builds product terms from the true and inverted forms of a set of input signals plus one signal fed back from the slice's own pin. Each literal enters a term only when its configuration bit is set. The terms are ORed into a single sum. A mode bit sends either that sum or the output of a D register to the pin. The register can be set or cleared asynchronously, has a clock enable, and has a preload path that writes a chosen value without going through the logic array. A power-on reset clears it.

The pin is modelled as a resolved level. A dedicated product term decides whether the slice drives the pin. When it does not, an external driver may set the level. When nobody drives, a keeper holds the level captured at the last rising clock edge. That captured level is also the feedback signal into the AND plane.

A small power-up sequencer has two states. HOLD is entered whenever power-on reset is asserted. The first rising edge after release is spent in HOLD without touching the register, and the transition HOLD to RUN is taken on that edge. RUN is kept from then on, and in RUN the preload and capture paths are live.

Top module: `plm_macrocell`

## Requirements
- R1: Literal 2k of the AND plane is the true form of signal k and literal 2k+1 its complement. Signals 0..N_IN-1 are `in_vec`, and signal N_IN is the pin feedback. Product term p uses mask bits [p*2*(N_IN+1) +: 2*(N_IN+1)] and is the AND of the literals whose mask bit is 1. A term with no literal selected is 1, and a term that selects both forms of one signal is 0.
- R2: `sop_out` is the OR of all N_PT product terms.
- R3: With `cfg_registered`=0 the slice drives `sop_out` to the pin. With `cfg_registered`=1 it drives `reg_q`.
- R4: In RUN, with no preload and no async control active, the register loads `sop_out` at a rising edge when `clk_en`=1 and holds its value when `clk_en`=0.
- R5: `async_clr` forces `reg_q` to 0 and `async_set` forces it to 1, both without a clock. When both are high, clear wins.
- R6: While `por_n`=0, `reg_q` and the keeper are 0 and the sequencer is in HOLD. The first rising edge after release changes neither `reg_q` nor applies preload.
- R7: In RUN, `preload_en`=1 loads `preload_val` at a rising edge, ahead of the normal capture. Asynchronous clear or set overrides it.
- R8: The output-enable term uses the mask `cfg_oe_mask` with the literal order of R1. When it is 0, `pad_level` follows `ext_drive_val` if `ext_drive_en`=1. Otherwise it holds the level `pad_level` had just before the last rising edge.
- R9: The feedback signal N_IN equals `pad_level` as captured at the last rising edge.
- R10: When the output-enable term is 1, `pad_level` is the slice's drive value whatever the external driver does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| async_set | input | 1 | Asynchronous register set, active high |
| async_clr | input | 1 | Asynchronous register clear, active high |
| clk_en | input | 1 | Clock enable for normal capture |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value written by preload |
| in_vec | input | N_IN | Array input signals |
| cfg_pt_mask | input | N_PT*2*(N_IN+1) | Literal masks of the sum terms |
| cfg_oe_mask | input | 2*(N_IN+1) | Literal mask of the output-enable term |
| cfg_registered | input | 1 | 1 selects the register output to the pin |
| ext_drive_en | input | 1 | An external driver is active on the pin |
| ext_drive_val | input | 1 | Level of the external driver |
| sop_out | output | 1 | OR of the product terms |
| reg_q | output | 1 | Register output |
| pad_oe | output | 1 | Output-enable term |
| pad_level | output | 1 | Resolved pin level |

## Verification
Sparse random masks are applied in combinational mode with the pin always driven. This separates literal order, polarity and the OR from one another, and the feedback literal makes each cycle depend on the previous pin level. Registered mode with random enables, random output-enable masks and external drivers shows whether capture, hold, keeper and driver priority agree with an independent model. Directed patterns cover the remaining cases: all-masked and contradictory terms, a set and clear overlap with preload, preload against capture, the ignored first edge after power-on, and a feedback term that reads back a level the keeper held.

// File: rtl/plm_pkg.sv
package plm_pkg;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } pwr_state_e;

    function automatic int lit_count(input int n_sig);
        return 2 * n_sig;
    endfunction

endpackage

// File: rtl/plm_pterm.sv
module plm_pterm #(
    parameter int N_LIT = 18
) (
    input  logic [N_LIT-1:0] lits,
    input  logic [N_LIT-1:0] mask,
    output logic             term
);
    // A masked-out literal contributes a 1 to the AND.
    assign term = &(lits | ~mask);
endmodule

// File: rtl/plm_and_plane.sv
module plm_and_plane #(
    parameter int N_SIG = 9,
    parameter int N_PT  = 4
) (
    input  logic [N_SIG-1:0]                     sig,
    input  logic [N_PT*plm_pkg::lit_count(N_SIG)-1:0] pt_mask,
    input  logic [plm_pkg::lit_count(N_SIG)-1:0]  oe_mask,
    output logic                                 sum,
    output logic                                 oe_term
);
    localparam int N_LIT = plm_pkg::lit_count(N_SIG);

    logic [N_LIT-1:0] lits;
    logic [N_PT-1:0]  terms;

    // Even literal: true form, odd literal: complement.
    for (genvar k = 0; k < N_SIG; k++) begin : g_lit
        assign lits[2*k]   = sig[k];
        assign lits[2*k+1] = ~sig[k];
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        plm_pterm #(.N_LIT(N_LIT)) u_term (
            .lits (lits),
            .mask (pt_mask[p*N_LIT +: N_LIT]),
            .term (terms[p])
        );
    end

    plm_pterm #(.N_LIT(N_LIT)) u_oe_term (
        .lits (lits),
        .mask (oe_mask),
        .term (oe_term)
    );

    assign sum = |terms;
endmodule

// File: rtl/plm_out_reg.sv
module plm_out_reg
    import plm_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic aset,
    input  logic aclr,
    input  logic ce,
    input  logic pl_req,
    input  logic pl_val,
    input  logic d,
    output logic q
);
    pwr_state_e st, st_nxt;
    logic       cap_en;
    logic       pl_en;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= ST_HOLD;
        else        st <= st_nxt;
    end

    // Next state: HOLD -> RUN on the first edge, RUN is kept
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_HOLD: st_nxt = ST_RUN;
            ST_RUN:  st_nxt = ST_RUN;
        endcase
    end

    // Outputs of the sequencer: which synchronous load is live
    always_comb begin
        cap_en = 1'b0;
        pl_en  = 1'b0;
        unique case (st)
            ST_HOLD: begin
                cap_en = 1'b0;
                pl_en  = 1'b0;
            end
            ST_RUN: begin
                pl_en  = pl_req;
                cap_en = ce & ~pl_req;
            end
        endcase
    end

    // Register: power-on, clear, set, preload, capture in falling priority
    always_ff @(posedge clk or negedge por_n or posedge aclr or posedge aset) begin
        if (!por_n)      q <= 1'b0;
        else if (aclr)   q <= 1'b0;
        else if (aset)   q <= 1'b1;
        else if (pl_en)  q <= pl_val;
        else if (cap_en) q <= d;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!por_n)
        aclr |-> !q) else $error("clear not honoured"); // R5

    AST_CAPTURE_OR_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        ($past(st == ST_RUN && !pl_req && !aset && !aclr) && !aset && !aclr)
        |-> q == ($past(ce) ? $past(d) : $past(q))) else $error("capture mismatch"); // R4

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!por_n)
        ($past(st == ST_RUN && pl_req && !aset && !aclr) && !aset && !aclr)
        |-> q == $past(pl_val)) else $error("preload mismatch"); // R7
endmodule

// File: rtl/plm_pad.sv
module plm_pad (
    input  logic clk,
    input  logic por_n,
    input  logic oe,
    input  logic drv,
    input  logic ext_en,
    input  logic ext_val,
    output logic level,
    output logic keep_q
);
    // Keeper samples the resolved level at every rising edge
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) keep_q <= 1'b0;
        else        keep_q <= level;
    end

    always_comb begin
        if (oe)          level = drv;
        else if (ext_en) level = ext_val;
        else             level = keep_q;
    end

    AST_KEEPER_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && !oe && !ext_en) |-> level == $past(level))
        else $error("keeper lost level"); // R8
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell #(
    parameter int N_IN = 8,
    parameter int N_PT = 4
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          async_set,
    input  logic                          async_clr,
    input  logic                          clk_en,
    input  logic                          preload_en,
    input  logic                          preload_val,
    input  logic [N_IN-1:0]               in_vec,
    input  logic [N_PT*2*(N_IN+1)-1:0]    cfg_pt_mask,
    input  logic [2*(N_IN+1)-1:0]         cfg_oe_mask,
    input  logic                          cfg_registered,
    input  logic                          ext_drive_en,
    input  logic                          ext_drive_val,
    output logic                          sop_out,
    output logic                          reg_q,
    output logic                          pad_oe,
    output logic                          pad_level
);
    localparam int N_SIG = N_IN + 1;

    logic [N_SIG-1:0] plane_sig;
    logic             keep_q;
    logic             drive_val;

    // The last signal of the plane is the captured pin level
    assign plane_sig = {keep_q, in_vec};

    plm_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) u_plane (
        .sig     (plane_sig),
        .pt_mask (cfg_pt_mask),
        .oe_mask (cfg_oe_mask),
        .sum     (sop_out),
        .oe_term (pad_oe)
    );

    plm_out_reg u_reg (
        .clk    (clk),
        .por_n  (por_n),
        .aset   (async_set),
        .aclr   (async_clr),
        .ce     (clk_en),
        .pl_req (preload_en),
        .pl_val (preload_val),
        .d      (sop_out),
        .q      (reg_q)
    );

    assign drive_val = cfg_registered ? reg_q : sop_out;

    plm_pad u_pad (
        .clk     (clk),
        .por_n   (por_n),
        .oe      (pad_oe),
        .drv     (drive_val),
        .ext_en  (ext_drive_en),
        .ext_val (ext_drive_val),
        .level   (pad_level),
        .keep_q  (keep_q)
    );

    AST_PIN_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_registered && pad_oe) |-> pad_level == reg_q)
        else $error("pin not register"); // R3

    AST_PIN_FOLLOWS_SUM: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_registered && pad_oe) |-> pad_level == sop_out)
        else $error("pin not sum"); // R3
endmodule

// File: tb/plm_macrocell_tb_top.sv
module plm_macrocell_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 8;
    localparam int N_PT  = 4;
    localparam int NLIT  = 2 * (N_IN + 1);
    localparam int MW    = N_PT * NLIT;

    logic clk = 1'b0;
    logic por_n, async_set, async_clr, clk_en, preload_en, preload_val;
    logic [N_IN-1:0] in_vec;
    logic [MW-1:0]   cfg_pt_mask;
    logic [NLIT-1:0] cfg_oe_mask;
    logic cfg_registered, ext_drive_en, ext_drive_val;
    logic sop_out, reg_q, pad_oe, pad_level;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic m_q, m_keep;

    always #(CLK_PERIOD/2) clk = ~clk;

    plm_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) dut_i (
        .clk(clk), .por_n(por_n), .async_set(async_set), .async_clr(async_clr),
        .clk_en(clk_en), .preload_en(preload_en), .preload_val(preload_val),
        .in_vec(in_vec), .cfg_pt_mask(cfg_pt_mask), .cfg_oe_mask(cfg_oe_mask),
        .cfg_registered(cfg_registered), .ext_drive_en(ext_drive_en),
        .ext_drive_val(ext_drive_val), .sop_out(sop_out), .reg_q(reg_q),
        .pad_oe(pad_oe), .pad_level(pad_level)
    );

    // Reference term: walk the signals and reject on any violated literal
    function automatic logic ref_term(input logic [NLIT-1:0] m,
                                      input logic [N_IN-1:0] iv, input logic fb);
        for (int k = 0; k <= N_IN; k++) begin
            logic v;
            v = (k == N_IN) ? fb : iv[k];
            if (m[2*k] && !v)  return 1'b0;
            if (m[2*k+1] && v) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic ref_sum(input logic [MW-1:0] m,
                                     input logic [N_IN-1:0] iv, input logic fb);
        logic s;
        s = 1'b0;
        for (int p = 0; p < N_PT; p++) s = s | ref_term(m[p*NLIT +: NLIT], iv, fb);
        return s;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // One cycle against the model: check sum and pin, step, check register
    task automatic run_cycle(input string tag);
        logic e_sop, e_oe, e_drv, e_pad;
        #2;
        e_sop = ref_sum(cfg_pt_mask, in_vec, m_keep);
        e_oe  = ref_term(cfg_oe_mask, in_vec, m_keep);
        e_drv = cfg_registered ? m_q : e_sop;
        e_pad = e_oe ? e_drv : (ext_drive_en ? ext_drive_val : m_keep);
        check({tag, " sum"}, sop_out, e_sop);
        check({tag, " oe"},  pad_oe,  e_oe);
        check({tag, " pin"}, pad_level, e_pad);
        if (preload_en)  m_q = preload_val;
        else if (clk_en) m_q = e_sop;
        m_keep = e_pad;
        tick();
        check({tag, " q"}, reg_q, m_q);
    endtask

    function automatic logic [NLIT-1:0] sparse_mask();
        return NLIT'($urandom & $urandom & $urandom);
    endfunction

    task automatic t_reset;
        por_n = 1'b0;
        cfg_registered = 1'b0;
        cfg_pt_mask = '0;
        cfg_oe_mask = '0;
        #(3*CLK_PERIOD);
        check("R6 q low in reset", reg_q, 1'b0);
        check("R1 empty terms give 1", sop_out, 1'b1);
        cfg_oe_mask = NLIT'(2'b11);
        #1;
        check("R6 keeper low in reset", pad_level, 1'b0);
        cfg_oe_mask = '0;
    endtask

    task automatic t_por_release;
        cfg_registered = 1'b1;
        clk_en = 1'b1;
        preload_en = 1'b1;
        preload_val = 1'b1;
        tick();
        por_n = 1'b1;
        tick();
        check("R6 first edge ignored", reg_q, 1'b0);
        tick();
        check("R7 preload after hold", reg_q, 1'b1);
        preload_en = 1'b0;
        m_q = 1'b1;
        m_keep = 1'b0;
    endtask

    task automatic t_random_comb;
        cfg_registered = 1'b0;
        cfg_oe_mask = '0;
        for (int i = 0; i < 150; i++) begin
            for (int p = 0; p < N_PT; p++) cfg_pt_mask[p*NLIT +: NLIT] = sparse_mask();
            in_vec = N_IN'($urandom);
            clk_en = 1'($urandom);
            ext_drive_en = 1'($urandom);
            ext_drive_val = 1'($urandom);
            run_cycle("R1 R2 R3 R9 R10 comb");
        end
    endtask

    task automatic t_random_reg;
        cfg_registered = 1'b1;
        for (int i = 0; i < 150; i++) begin
            for (int p = 0; p < N_PT; p++) cfg_pt_mask[p*NLIT +: NLIT] = sparse_mask();
            cfg_oe_mask = sparse_mask() | NLIT'($urandom & 3);
            in_vec = N_IN'($urandom);
            clk_en = 1'($urandom);
            preload_en = (($urandom % 8) == 0);
            preload_val = 1'($urandom);
            ext_drive_en = 1'($urandom);
            ext_drive_val = 1'($urandom);
            run_cycle("R3 R4 R7 R8 reg");
        end
        preload_en = 1'b0;
    endtask

    task automatic t_literals;
        cfg_registered = 1'b0;
        cfg_oe_mask = '0;
        clk_en = 1'b0;
        cfg_pt_mask = '0;
        run_cycle("R1 all masked");
        for (int p = 0; p < N_PT; p++) cfg_pt_mask[p*NLIT +: NLIT] = NLIT'(2'b11);
        run_cycle("R1 contradictory");
        cfg_pt_mask[1:0] = 2'b10;
        in_vec = '0;
        run_cycle("R1 complement literal low input");
        in_vec = N_IN'(1);
        run_cycle("R1 complement literal high input");
        cfg_pt_mask[NLIT +: NLIT] = NLIT'(1) << 6;
        in_vec = N_IN'(8);
        run_cycle("R2 second term true literal");
    endtask

    task automatic t_async;
        cfg_registered = 1'b1;
        cfg_oe_mask = '0;
        clk_en = 1'b0;
        preload_en = 1'b0;
        async_clr = 1'b1;
        #2;
        check("R5 clear without clock", reg_q, 1'b0);
        async_clr = 1'b0;
        #1;
        async_set = 1'b1;
        #2;
        check("R5 set without clock", reg_q, 1'b1);
        async_clr = 1'b1;
        #1;
        check("R5 clear over set", reg_q, 1'b0);
        preload_en = 1'b1;
        preload_val = 1'b1;
        tick();
        check("R7 preload yields to clear", reg_q, 1'b0);
        async_clr = 1'b0;
        preload_val = 1'b0;
        tick();
        check("R5 set over preload", reg_q, 1'b1);
        async_set = 1'b0;
        preload_en = 1'b0;
        m_q = 1'b1;
        m_keep = 1'b0;
    endtask

    task automatic t_priority;
        cfg_registered = 1'b1;
        cfg_oe_mask = '0;
        cfg_pt_mask = '0;
        clk_en = 1'b1;
        preload_en = 1'b1;
        preload_val = 1'b0;
        run_cycle("R7 preload over capture");
        preload_en = 1'b0;
        run_cycle("R4 capture sum");
        for (int p = 0; p < N_PT; p++) cfg_pt_mask[p*NLIT +: NLIT] = NLIT'(2'b11);
        clk_en = 1'b0;
        run_cycle("R4 hold with enable low");
        clk_en = 1'b1;
        run_cycle("R4 capture zero");
    endtask

    task automatic t_keeper;
        cfg_registered = 1'b0;
        clk_en = 1'b0;
        cfg_oe_mask = NLIT'(2'b11);
        for (int p = 0; p < N_PT; p++) cfg_pt_mask[p*NLIT +: NLIT] = NLIT'(2'b11);
        cfg_pt_mask[NLIT-2] = 1'b1;
        cfg_pt_mask[1:0] = 2'b00;
        ext_drive_en = 1'b1;
        ext_drive_val = 1'b1;
        run_cycle("R8 external drives high");
        ext_drive_en = 1'b0;
        run_cycle("R8 R9 keeper holds high");
        ext_drive_en = 1'b1;
        ext_drive_val = 1'b0;
        run_cycle("R8 external drives low");
        ext_drive_en = 1'b0;
        run_cycle("R8 R9 keeper holds low");
        cfg_oe_mask = '0;
        ext_drive_en = 1'b1;
        ext_drive_val = 1'b1;
        run_cycle("R10 slice overrides external");
        ext_drive_en = 1'b0;
    endtask

    initial begin
        async_set = 1'b0; async_clr = 1'b0; clk_en = 1'b0;
        preload_en = 1'b0; preload_val = 1'b0; in_vec = '0;
        ext_drive_en = 1'b0; ext_drive_val = 1'b0;
        m_q = 1'b0; m_keep = 1'b0;
        t_reset();
        t_por_release();
        t_random_comb();
        t_literals();
        t_async();
        t_priority();
        t_random_reg();
        t_keeper();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule